// File: doc/BRIEF.md
# Local Bus Chip-Select Bank Decoder

This block sits between an on-chip bus master and a set of external memory banks. It holds one configuration word per bank and compares the upper bits of each incoming transaction address against them. It then registers a one-hot chip select together with the winning bank's port width and machine selection. Software sets up each bank through a small register port. A separate mask input for each bank decides which address bits take part in the comparison. A mask bit of 1 means the bit is compared; a mask bit of 0 means it is ignored.

Bank 0 is usable straight after reset. Its port width and machine selection are taken from boot configuration inputs, so a boot memory can be fetched before any register is written. Any bank can be made read-only. A write that reaches a read-only bank gets no chip select and is terminated. The write also leaves a sticky error flag, which can raise an interrupt when enabled.

Top module: `cs_bank_decoder`

## Requirements
- R1: Synchronous active-low reset leaves bank 0 valid, with its port-size field equal to `boot_port_size` (made legal as in R10) and its machine bit equal to `boot_flash_sel`. All other bits of bank 0 and every bit of banks 1 to 3 are zero. The error flag, the interrupt enable and all decode outputs are also zero.
- R2: Bank n's configuration word sits at register offset 0x5000 + 8*n. A write (`reg_we` high) takes effect at the next clock edge. `reg_rdata` shows the word at `reg_addr` combinationally, with every unlisted bit reading zero. Word layout: base [31:15], port size [12:11] (01 = 8-bit, 10 = 16-bit), check mode [10:9], write protect [8], machine select [5] (1 = flash machine), valid [0].
- R3: In the cycle after `bus_valid` is sampled high, `chip_sel` has exactly the bit of the winning bank set. `sel_port_size` and `sel_flash` carry that bank's fields. A bank matches when its valid bit is 1 and `bus_addr_hi` equals its base on every bit where its mask is 1.
- R4: A bank whose valid bit is 0 never matches, whatever its base and mask.
- R5: When several banks match, the lowest-numbered one wins.
- R6: A transaction that matches no bank gives `chip_sel` = 0 and a `no_hit` pulse one cycle long in the following cycle. With no transaction, all decode outputs are 0.
- R7: If the winning bank has write protect set, a read is decoded normally. A write instead gives `chip_sel` = 0 and a one-cycle `wp_abort` pulse, and it sets the error flag.
- R8: The status word at offset 0x5020 has bit 0 = error flag and bit 1 = interrupt enable. The flag stays set until a status write with bit 0 = 1 clears it. A clear in the same cycle as a new violation leaves the flag set.
- R9: `bus_err_irq` is high exactly when the error flag and the interrupt enable are both 1.
- R10: A configuration with machine select 1 and port size 10 is stored with port size 01. This applies both to register writes and to boot values.
- R11: Reads of unmapped offsets return zero, and writes to them change no register.
- R12: A transaction is decoded against the configuration held before a register write made in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| boot_port_size | input | 2 | Bank 0 port size loaded at reset |
| boot_flash_sel | input | 1 | Bank 0 machine select loaded at reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 16 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data at `reg_addr` |
| bank_mask | input | 68 | Per-bank 17-bit compare masks, bank n at [17n+16:17n] |
| bus_valid | input | 1 | Transaction present this cycle |
| bus_write | input | 1 | Transaction is a write |
| bus_addr_hi | input | 17 | Upper 17 bits of the transaction address |
| chip_sel | output | 4 | One-hot bank select, registered |
| sel_port_size | output | 2 | Port size of the winning bank |
| sel_flash | output | 1 | Machine select of the winning bank |
| no_hit | output | 1 | Pulse: transaction matched no bank |
| wp_abort | output | 1 | Pulse: write to a protected bank terminated |
| bus_err_irq | output | 1 | Write-protect error interrupt request |

## Verification
Two collisions need care. The first is a protection violation that arrives in the same cycle as the software write-one-to-clear of the error flag. The bench provokes it by issuing a protected write and a status write with bit 0 set in one step, and it expects the flag and, with the enable set, the interrupt to stay high afterwards. The second is a bank reconfiguration that arrives in the same cycle as a transaction to that bank. There the bench expects the decode to follow the old word and only the next transaction to see the new one. Both cases, and long random mixes of register writes and traffic, are judged against a behavioural model that is advanced on every clock.

// File: rtl/cs_bank_pkg.sv
// Package: shared configuration type and word packing for the bank decoder.
// Assumes a 17-bit base compare field and a 32-bit register word.
package cs_bank_pkg;

    localparam int BASE_W = 17;
    localparam int WORD_W = 32;

    typedef struct packed {
        logic [BASE_W-1:0] base;
        logic [1:0]        psize;
        logic [1:0]        chk;
        logic              wprot;
        logic              flash;
        logic              valid;
    } bank_cfg_t;

    // Replace the forbidden flash + 16-bit pairing with 8-bit width.
    function automatic bank_cfg_t legalize(input bank_cfg_t c);
        bank_cfg_t r;
        r = c;
        if (c.flash && c.psize == 2'b10) begin
            r.psize = 2'b01;
        end
        return r;
    endfunction

    // Unpack a register word into the stored configuration.
    function automatic bank_cfg_t word_to_cfg(input logic [WORD_W-1:0] w);
        bank_cfg_t c;
        c.base  = w[31:15];
        c.psize = w[12:11];
        c.chk   = w[10:9];
        c.wprot = w[8];
        c.flash = w[5];
        c.valid = w[0];
        return legalize(c);
    endfunction

    // Pack the stored configuration into a register word, reserved bits zero.
    function automatic logic [WORD_W-1:0] cfg_to_word(input bank_cfg_t c);
        logic [WORD_W-1:0] w;
        w        = '0;
        w[31:15] = c.base;
        w[12:11] = c.psize;
        w[10:9]  = c.chk;
        w[8]     = c.wprot;
        w[5]     = c.flash;
        w[0]     = c.valid;
        return w;
    endfunction

endpackage

// File: rtl/cs_bank_regfile.sv
// Bank configuration registers and status enable, with a combinational read port.
// Assumes byte offsets: bank n at REG_BASE + n*REG_STRIDE, status just after the last bank.
module cs_bank_regfile
    import cs_bank_pkg::*;
#(
    parameter int          NUM_BANKS  = 4,
    parameter int          REG_AW     = 16,
    parameter int unsigned REG_BASE   = 32'h5000,
    parameter int unsigned REG_STRIDE = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        boot_ps,
    input  logic              boot_flash,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [WORD_W-1:0] reg_wdata,
    input  logic              flag_q,
    output bank_cfg_t         cfg [NUM_BANKS],
    output logic              irq_en,
    output logic              clr_req,
    output logic [WORD_W-1:0] reg_rdata
);

    localparam int unsigned STAT_OFS = REG_BASE + NUM_BANKS * REG_STRIDE;

    logic [NUM_BANKS-1:0] addr_hit;
    logic                 stat_hit;
    bank_cfg_t            boot_cfg;

    // Bank 0 reset image built from the boot inputs.
    always_comb begin
        boot_cfg       = '0;
        boot_cfg.psize = boot_ps;
        boot_cfg.flash = boot_flash;
        boot_cfg.valid = 1'b1;
        boot_cfg       = legalize(boot_cfg);
    end

    assign stat_hit = (reg_addr == REG_AW'(STAT_OFS));
    assign clr_req  = reg_we && stat_hit && reg_wdata[0];

    for (genvar i = 0; i < NUM_BANKS; i++) begin : g_bank
        assign addr_hit[i] = (reg_addr == REG_AW'(REG_BASE + i * REG_STRIDE));

        // Hold one bank word: boot image or zero at reset, software write otherwise.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cfg[i] <= (i == 0) ? boot_cfg : '0;
            end else if (reg_we && addr_hit[i]) begin
                cfg[i] <= word_to_cfg(reg_wdata);
            end
        end

        a_r10_no_flash16 : assert property (@(posedge clk) disable iff (!rst_n)
            !(cfg[i].flash && cfg[i].psize == 2'b10));
    end

    // Interrupt enable bit of the status word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_en <= 1'b0;
        end else if (reg_we && stat_hit) begin
            irq_en <= reg_wdata[1];
        end
    end

    // Read multiplexer; unmapped offsets return zero.
    always_comb begin
        reg_rdata = '0;
        for (int i = 0; i < NUM_BANKS; i++) begin
            if (addr_hit[i]) begin
                reg_rdata = cfg_to_word(cfg[i]);
            end
        end
        if (stat_hit) begin
            reg_rdata[1:0] = {irq_en, flag_q};
        end
    end

endmodule

// File: rtl/cs_bank_matcher.sv
// Masked address compare for every bank and lowest-index priority pick.
// Purely combinational; assumes NUM_BANKS >= 2.
module cs_bank_matcher
    import cs_bank_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    localparam int IDX_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  bank_cfg_t                   cfg [NUM_BANKS],
    input  logic [NUM_BANKS*BASE_W-1:0] mask,
    input  logic [BASE_W-1:0]           addr_hi,
    output logic [NUM_BANKS-1:0]        win,
    output logic [IDX_W-1:0]            win_idx,
    output logic                        any
);

    logic [NUM_BANKS-1:0] match;

    for (genvar i = 0; i < NUM_BANKS; i++) begin : g_cmp
        assign match[i] = cfg[i].valid &&
            (((addr_hi ^ cfg[i].base) & mask[i*BASE_W +: BASE_W]) == '0);
    end

    // Walk from the top bank down so the lowest matching index is kept.
    always_comb begin
        win     = '0;
        win_idx = '0;
        any     = 1'b0;
        for (int i = NUM_BANKS - 1; i >= 0; i--) begin
            if (match[i]) begin
                win     = '0;
                win[i]  = 1'b1;
                win_idx = IDX_W'(i);
                any     = 1'b1;
            end
        end
    end

endmodule

// File: rtl/cs_wp_error.sv
// Sticky write-protect error flag with write-one-to-clear and gated interrupt.
// Assumes a set request beats a clear request in the same cycle.
module cs_wp_error (
    input  logic clk,
    input  logic rst_n,
    input  logic set_req,
    input  logic clr_req,
    input  logic irq_en,
    output logic flag_q,
    output logic irq
);

    // Flag register: set has priority over software clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (set_req) begin
            flag_q <= 1'b1;
        end else if (clr_req) begin
            flag_q <= 1'b0;
        end
    end

    assign irq = flag_q && irq_en;

    a_r8_set_wins : assert property (@(posedge clk) disable iff (!rst_n)
        set_req |=> flag_q);
    a_r8_sticky : assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !clr_req) |=> flag_q);
    a_r8_clears : assert property (@(posedge clk) disable iff (!rst_n)
        (clr_req && !set_req) |=> !flag_q);

endmodule

// File: rtl/cs_bank_decoder.sv
// Top: bank registers, address matcher and write-protect error unit, with
// registered decode outputs one cycle after the transaction is sampled.
// Assumes a single-cycle transaction strobe and the upper address bits only.
module cs_bank_decoder
    import cs_bank_pkg::*;
#(
    parameter int          NUM_BANKS  = 4,
    parameter int          REG_AW     = 16,
    parameter int unsigned REG_BASE   = 32'h5000,
    parameter int unsigned REG_STRIDE = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [1:0]                  boot_port_size,
    input  logic                        boot_flash_sel,
    input  logic                        reg_we,
    input  logic [REG_AW-1:0]           reg_addr,
    input  logic [WORD_W-1:0]           reg_wdata,
    output logic [WORD_W-1:0]           reg_rdata,
    input  logic [NUM_BANKS*BASE_W-1:0] bank_mask,
    input  logic                        bus_valid,
    input  logic                        bus_write,
    input  logic [BASE_W-1:0]           bus_addr_hi,
    output logic [NUM_BANKS-1:0]        chip_sel,
    output logic [1:0]                  sel_port_size,
    output logic                        sel_flash,
    output logic                        no_hit,
    output logic                        wp_abort,
    output logic                        bus_err_irq
);

    localparam int IDX_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;

    bank_cfg_t            cfg [NUM_BANKS];
    logic [NUM_BANKS-1:0] win;
    logic [IDX_W-1:0]     win_idx;
    logic                 any;
    logic                 irq_en;
    logic                 clr_req;
    logic                 flag_q;
    logic                 viol;
    bank_cfg_t            wcfg;

    cs_bank_regfile #(
        .NUM_BANKS (NUM_BANKS),
        .REG_AW    (REG_AW),
        .REG_BASE  (REG_BASE),
        .REG_STRIDE(REG_STRIDE)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .boot_ps   (boot_port_size),
        .boot_flash(boot_flash_sel),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .flag_q    (flag_q),
        .cfg       (cfg),
        .irq_en    (irq_en),
        .clr_req   (clr_req),
        .reg_rdata (reg_rdata)
    );

    cs_bank_matcher #(
        .NUM_BANKS(NUM_BANKS)
    ) u_match (
        .cfg    (cfg),
        .mask   (bank_mask),
        .addr_hi(bus_addr_hi),
        .win    (win),
        .win_idx(win_idx),
        .any    (any)
    );

    assign wcfg = cfg[win_idx];
    assign viol = bus_valid && bus_write && any && wcfg.wprot;

    cs_wp_error u_err (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_req(viol),
        .clr_req(clr_req),
        .irq_en (irq_en),
        .flag_q (flag_q),
        .irq    (bus_err_irq)
    );

    // Register the decode result; everything idles low between transactions.
    always_ff @(posedge clk) begin
        if (!rst_n || !bus_valid) begin
            chip_sel      <= '0;
            sel_port_size <= '0;
            sel_flash     <= 1'b0;
            no_hit        <= 1'b0;
            wp_abort      <= 1'b0;
        end else begin
            chip_sel      <= viol ? '0 : win;
            sel_port_size <= any ? wcfg.psize : 2'b00;
            sel_flash     <= any && wcfg.flash;
            no_hit        <= !any;
            wp_abort      <= viol;
        end
    end

    a_r3_cs_onehot : assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(chip_sel));
    a_r3_cs_needs_bus : assert property (@(posedge clk) disable iff (!rst_n)
        (chip_sel != '0) |-> $past(bus_valid));
    a_r6_nohit_clean : assert property (@(posedge clk) disable iff (!rst_n)
        no_hit |-> (chip_sel == '0 && !wp_abort));
    a_r7_abort_clean : assert property (@(posedge clk) disable iff (!rst_n)
        wp_abort |-> (chip_sel == '0 && flag_q));

endmodule

// File: tb/test_cs_bank_decoder.sv
`timescale 1ns/1ps
module test_cs_bank_decoder;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  boot_port_size = 2'b10;
    logic        boot_flash_sel = 1'b0;
    logic        reg_we = 1'b0;
    logic [15:0] reg_addr = 16'h5000;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [67:0] bank_mask;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [16:0] bus_addr_hi = '0;
    logic [3:0]  chip_sel;
    logic [1:0]  sel_port_size;
    logic        sel_flash;
    logic        no_hit;
    logic        wp_abort;
    logic        bus_err_irq;

    logic [16:0] bm [4];
    assign bank_mask = {bm[3], bm[2], bm[1], bm[0]};

    always #2 clk = ~clk;

    cs_bank_decoder i_cs_bank_decoder (
        .clk(clk), .rst_n(rst_n),
        .boot_port_size(boot_port_size), .boot_flash_sel(boot_flash_sel),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .bank_mask(bank_mask),
        .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr_hi(bus_addr_hi),
        .chip_sel(chip_sel), .sel_port_size(sel_port_size), .sel_flash(sel_flash),
        .no_hit(no_hit), .wp_abort(wp_abort), .bus_err_irq(bus_err_irq)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // Behavioural reference state.
    logic [31:0] m_reg [4];
    bit          m_flag, m_en;
    logic [3:0]  e_cs;
    logic [1:0]  e_ps;
    bit          e_fl, e_nohit, e_abort;

    function automatic logic [31:0] mkw(input logic [16:0] b, input logic [1:0] ps,
        input logic [1:0] ck, input bit wp, input bit fl, input bit v);
        return {b, 2'b00, ps, ck, wp, 2'b00, fl, 4'b0000, v};
    endfunction

    function automatic logic [31:0] legal(input logic [31:0] w);
        logic [31:0] r;
        r = w & 32'hFFFF_9F21;
        if (r[5] && r[12:11] == 2'b10) r[12:11] = 2'b01;
        return r;
    endfunction

    function automatic logic [31:0] m_read(input logic [15:0] a);
        for (int i = 0; i < 4; i++) if (a == 16'h5000 + 16'(8 * i)) return m_reg[i];
        if (a == 16'h5020) return {30'b0, m_en, m_flag};
        return 32'h0;
    endfunction

    // Advance the model on each clock from the inputs sampled there.
    always @(posedge clk) begin
        int  w;
        bit  setf, clrf;
        if (!rst_n) begin
            m_reg[0] = legal(mkw(17'h0, boot_port_size, 2'b00, 1'b0, boot_flash_sel, 1'b1));
            for (int i = 1; i < 4; i++) m_reg[i] = 32'h0;
            m_flag = 0; m_en = 0;
            e_cs = 0; e_ps = 0; e_fl = 0; e_nohit = 0; e_abort = 0;
        end else begin
            w = -1;
            for (int i = 0; i < 4; i++)
                if (w < 0 && m_reg[i][0] &&
                    (((bus_addr_hi ^ m_reg[i][31:15]) & bm[i]) == 17'h0)) w = i;
            e_cs = 0; e_ps = 0; e_fl = 0; e_nohit = 0; e_abort = 0; setf = 0; clrf = 0;
            if (bus_valid) begin
                if (w < 0) e_nohit = 1;
                else begin
                    e_ps = m_reg[w][12:11];
                    e_fl = m_reg[w][5];
                    if (m_reg[w][8] && bus_write) begin e_abort = 1; setf = 1; end
                    else e_cs = 4'(1 << w);
                end
            end
            if (reg_we) begin
                for (int i = 0; i < 4; i++)
                    if (reg_addr == 16'h5000 + 16'(8 * i)) m_reg[i] = legal(reg_wdata);
                if (reg_addr == 16'h5020) begin m_en = reg_wdata[1]; clrf = reg_wdata[0]; end
            end
            m_flag = setf | (m_flag & ~clrf);
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Apply one cycle of stimulus, then compare every output against the model.
    task automatic step(input bit we, input logic [15:0] a, input logic [31:0] d,
                        input bit bv, input bit bw, input logic [16:0] ba);
        reg_we = we; reg_addr = a; reg_wdata = d;
        bus_valid = bv; bus_write = bw; bus_addr_hi = ba;
        @(posedge clk);
        @(negedge clk);
        chk("R3 chip_sel", 32'(chip_sel), 32'(e_cs));
        chk("R3 port size", 32'(sel_port_size), 32'(e_ps));
        chk("R3 flash sel", 32'(sel_flash), 32'(e_fl));
        chk("R6 no_hit", 32'(no_hit), 32'(e_nohit));
        chk("R7 wp_abort", 32'(wp_abort), 32'(e_abort));
        chk("R9 irq", 32'(bus_err_irq), 32'(m_flag & m_en));
        chk("R2 readback", reg_rdata, m_read(a));
    endtask

    task automatic idle(input logic [15:0] a);
        step(0, a, 0, 0, 0, 0);
    endtask

    initial begin
        for (int i = 0; i < 4; i++) bm[i] = 17'h1FFFF;
        rst_n = 0;
        repeat (3) idle(16'h5000);
        chk("R1 bank0 boot word", reg_rdata, 32'h0000_1001);
        chk("R1 outputs idle", 32'({chip_sel, no_hit, wp_abort, bus_err_irq}), 32'h0);
        rst_n = 1;
        idle(16'h5008);
        chk("R1 bank1 zero", reg_rdata, 32'h0);
        idle(16'h5020);
        chk("R1 status zero", reg_rdata, 32'h0);

        // R3: bank0 decodes straight after reset.
        step(0, 16'h5000, 0, 1, 0, 17'h00000);
        chk("R3 boot bank hit", 32'(chip_sel), 32'h1);
        chk("R3 boot bank size", 32'(sel_port_size), 32'h2);

        // R2/R12: write bank1 while a transaction to its new base is in flight.
        step(1, 16'h5008, mkw(17'h00010, 2'b01, 2'b10, 0, 1, 1), 1, 0, 17'h00010);
        chk("R12 old config used", 32'(no_hit), 32'h1);
        chk("R2 bank1 written", reg_rdata, 32'h0008_0C21);
        step(0, 16'h5008, 0, 1, 0, 17'h00010);
        chk("R3 bank1 hit", 32'(chip_sel), 32'h2);
        chk("R3 bank1 flash", 32'(sel_flash), 32'h1);
        idle(16'h5008);
        chk("R6 no_hit one cycle", 32'(no_hit), 32'h0);

        // R2: reserved bits read zero.
        step(1, 16'h5018, 32'hFFFF_FFFF, 0, 0, 0);
        chk("R2 reserved zero", reg_rdata, 32'hFFFF_9F21);
        // R4: invalid bank3 never matches.
        step(1, 16'h5018, mkw(17'h00300, 2'b01, 0, 0, 0, 0), 1, 0, 17'h1FFFF);
        step(0, 16'h5018, 0, 1, 0, 17'h00300);
        chk("R4 invalid ignored", 32'({chip_sel, no_hit}), 32'h1);

        // R3 masked compare: bank2 compares top 5 bits only.
        bm[2] = 17'h1F000;
        step(1, 16'h5010, mkw(17'h10000, 2'b10, 0, 0, 0, 1), 0, 0, 0);
        step(0, 16'h5010, 0, 1, 0, 17'h10ABC);
        chk("R3 masked hit", 32'(chip_sel), 32'h4);

        // R5: bank2 widened to match everything, lower banks still win.
        bm[2] = 17'h0;
        step(0, 16'h5010, 0, 1, 0, 17'h00010);
        chk("R5 bank1 over bank2", 32'(chip_sel), 32'h2);
        step(0, 16'h5010, 0, 1, 0, 17'h00000);
        chk("R5 bank0 over bank2", 32'(chip_sel), 32'h1);
        bm[2] = 17'h1F000;

        // R7: protect bank1.
        step(1, 16'h5008, mkw(17'h00010, 2'b01, 0, 1, 0, 1), 0, 0, 0);
        step(0, 16'h5020, 0, 1, 0, 17'h00010);
        chk("R7 read passes", 32'(chip_sel), 32'h2);
        step(0, 16'h5020, 0, 1, 1, 17'h00010);
        chk("R7 write blocked", 32'({chip_sel, wp_abort}), 32'h1);
        chk("R8 flag set", reg_rdata, 32'h1);
        chk("R9 irq off", 32'(bus_err_irq), 32'h0);
        step(1, 16'h5020, 32'h2, 0, 0, 0);
        chk("R9 irq on", 32'(bus_err_irq), 32'h1);
        idle(16'h5020);
        chk("R8 sticky", reg_rdata, 32'h3);
        // R8 collision: clear together with a new violation.
        step(1, 16'h5020, 32'h3, 1, 1, 17'h00010);
        chk("R8 set beats clear", reg_rdata, 32'h3);
        step(1, 16'h5020, 32'h3, 0, 0, 0);
        chk("R8 cleared", reg_rdata, 32'h2);
        chk("R9 irq dropped", 32'(bus_err_irq), 32'h0);

        // R10: flash with 16-bit becomes 8-bit.
        step(1, 16'h5018, mkw(17'h00400, 2'b10, 0, 0, 1, 1), 0, 0, 0);
        chk("R10 legalized write", 32'(reg_rdata[12:11]), 32'h1);

        // R11: unmapped offsets.
        step(1, 16'h5004, 32'hFFFF_FFFF, 0, 0, 0);
        chk("R11 unmapped read", reg_rdata, 32'h0);
        idle(16'h5000);
        chk("R11 bank0 untouched", reg_rdata, 32'h0000_1001);
        idle(16'h5028);
        chk("R11 beyond status", reg_rdata, 32'h0);

        // Random mix against the model.
        for (int k = 0; k < 3000; k++) begin
            logic [15:0] a;
            logic [31:0] d;
            a = 16'h5000 + 16'(8 * ($urandom % 5));
            d = $urandom;
            if (a == 16'h5020) d[0] = ($urandom % 4) == 0;
            if ($urandom % 8 == 0) bm[$urandom % 4] = 17'($urandom);
            step(($urandom % 4) == 0, a, d, ($urandom % 3) != 0, $urandom % 2,
                 ($urandom % 2) ? d[31:15] : 17'($urandom));
        end

        // R1/R10: boot with flash and 16-bit.
        rst_n = 0;
        boot_flash_sel = 1;
        boot_port_size = 2'b10;
        repeat (2) idle(16'h5000);
        rst_n = 1;
        idle(16'h5000);
        chk("R10 boot legalized", reg_rdata, 32'h0000_0821);
        step(0, 16'h5000, 0, 1, 0, 17'h0);
        chk("R1 flash boot hit", 32'({chip_sel, sel_port_size, sel_flash}), 32'h0B);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule